// File: doc/BRIEF.md
# TDM Backplane Clock and Frame Pulse Generator

This block turns a 16.384 MHz master clock into the timing signals of a time-division multiplexed backplane. It produces clocks at 8.192, 4.096 and 2.048 MHz and two active-low 8 kHz frame pulses. One pulse is shaped for the 4.096 MHz clock and the other for the 8.192 MHz clock. Every output comes from a single free-running frame counter. Because of this, the phase of each output against the others is fixed once reset is released.

A small output control register holds one enable bit per output and one timing-source bit. When an output's enable bit is clear, that output sits at a static high level. The 8.192 MHz clock pin and its frame pin are bidirectional pads, so the block drives a data value and an output-enable for each. When the timing-source bit selects external backplane timing, those two pads are released as inputs and their enable bits have no effect. In the default local mode the block drives every enabled output itself and needs no frame pulse from outside.

Top module: `tdm_clkgen`

## Requirements
- R1: While reset is asserted and after it is released, the configuration register holds local mode (external bit 0) and all enable bits clear. Until it is written, clk2_o, clk4_o, fp4_o, c8_o and f8_o are all 1, and c8_oe and f8_oe are 0.
- R2: The frame index starts at 0 in reset and advances by one on each rising clock edge after reset, wrapping after FRAME_CYCLES (default 2048, i.e. 8 kHz at 16.384 MHz). Registered outputs after the edge that produces index n reflect index n.
- R3: When the 8 MHz clock is enabled (cfg_en bit 2) in local mode, c8_oe is 1 and c8_o equals bit 0 of the frame index. It is low on even indices, so it toggles every master cycle.
- R4: When enabled, clk4_o (cfg_en bit 1) equals bit 1 of the frame index and clk2_o (cfg_en bit 0) equals bit 2. All three clocks are low at index 0.
- R5: When the 8 MHz frame pulse is enabled (cfg_en bit 4) in local mode, f8_oe is 1 and f8_o is low exactly at indices FRAME_CYCLES-1 and 0. That is one 8 MHz period centred on the frame boundary.
- R6: When the 4 MHz frame pulse is enabled (cfg_en bit 3), fp4_o is low exactly at indices FRAME_CYCLES-2, FRAME_CYCLES-1, 0 and 1. That is one 4 MHz period centred on the frame boundary.
- R7: With its enable bit clear, an output is held at 1 rather than toggling. For the two bidirectional pads the output-enable is also 0.
- R8: With the external-timing bit set (cfg_ext = 1), c8_oe and f8_oe are 0 and c8_o and f8_o are 1 whatever their enable bits say. The other outputs and the frame index are unaffected.
- R9: A configuration presented with cfg_wr high is taken at that rising edge, and the outputs registered at the same edge already follow it. With cfg_wr low, changes on cfg_en and cfg_ext have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the output control register |
| cfg_en | input | 5 | Enable bits: 0 clk2, 1 clk4, 2 c8, 3 fp4, 4 f8 |
| cfg_ext | input | 1 | 1 selects external timing (pads become inputs) |
| clk2_o | output | 1 | 2.048 MHz clock |
| clk4_o | output | 1 | 4.096 MHz clock |
| fp4_o | output | 1 | Active-low frame pulse aligned to the 4.096 MHz clock |
| c8_o | output | 1 | Data value for the bidirectional 8.192 MHz clock pad |
| c8_oe | output | 1 | Output-enable for the 8.192 MHz clock pad |
| f8_o | output | 1 | Data value for the bidirectional frame pad (8 MHz aligned) |
| f8_oe | output | 1 | Output-enable for the bidirectional frame pad |

## Verification
The bench builds the block with FRAME_CYCLES set to 64 instead of 2048. This lets a few hundred cycles cover several frame wraps and both pulse windows, under every enable pattern and in both timing modes. The shortened frame also makes the pulse windows at indices FRAME_CYCLES-2 and FRAME_CYCLES-1 come up often, together with the wrap to 0. A reset in the middle of a run confirms that the phase always restarts from index 0.

// File: rtl/tdm_clkgen_pkg.sv
package tdm_clkgen_pkg;

    localparam int N_OUT  = 5;
    localparam int EN_C2  = 0;
    localparam int EN_C4  = 1;
    localparam int EN_C8  = 2;
    localparam int EN_FP4 = 3;
    localparam int EN_FP8 = 4;

    // number of divided clocks; clock k toggles every 2^k master cycles
    localparam int N_CLK  = 3;
    localparam int CK_C8  = 0;
    localparam int CK_C4  = 1;
    localparam int CK_C2  = 2;

    typedef struct packed {
        logic [N_OUT-1:0] en;
        logic             ext;
    } cfg_t;

    typedef struct packed {
        logic c2;
        logic c4;
        logic fp4;
        logic c8;
        logic c8_oe;
        logic f8;
        logic f8_oe;
    } pins_t;

    localparam cfg_t  CFG_RST  = '{en: '0, ext: 1'b0};
    localparam pins_t PINS_RST = '{c2: 1'b1, c4: 1'b1, fp4: 1'b1, c8: 1'b1,
                                   c8_oe: 1'b0, f8: 1'b1, f8_oe: 1'b0};

endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
    parameter int FRAME_CYCLES = 2048,
    localparam int CNT_W = $clog2(FRAME_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

    always_comb begin
        if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/tdm_clk_div.sv
module tdm_clk_div #(
    parameter int CNT_W = 11,
    parameter int N_CLK = 3
) (
    input  logic [CNT_W-1:0] idx,
    output logic [N_CLK-1:0] clk_lvl
);

    // clock k is low in the first half of each 2^(k+1)-cycle period
    for (genvar k = 0; k < N_CLK; k++) begin : g_div
        assign clk_lvl[k] = idx[k];
    end

endmodule

// File: rtl/tdm_fp_shaper.sv
module tdm_fp_shaper #(
    parameter int FRAME_CYCLES = 2048,
    parameter int HALF_WIDTH   = 1,
    localparam int CNT_W = $clog2(FRAME_CYCLES)
) (
    input  logic [CNT_W-1:0] idx,
    output logic             fp_n
);

    localparam logic [CNT_W-1:0] LATE_START = CNT_W'(FRAME_CYCLES - HALF_WIDTH);
    localparam logic [CNT_W-1:0] EARLY_END  = CNT_W'(HALF_WIDTH);

    logic in_window;

    always_comb begin
        in_window = (idx >= LATE_START) || (idx < EARLY_END);
        fp_n      = ~in_window;
    end

endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
    import tdm_clkgen_pkg::*;
#(
    parameter int FRAME_CYCLES = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [N_OUT-1:0] cfg_en,
    input  logic             cfg_ext,
    output logic             clk2_o,
    output logic             clk4_o,
    output logic             fp4_o,
    output logic             c8_o,
    output logic             c8_oe,
    output logic             f8_o,
    output logic             f8_oe
);

    localparam int CNT_W = $clog2(FRAME_CYCLES);

    typedef struct packed {
        cfg_t  cfg;
        pins_t pins;
    } state_t;

    state_t q, d;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [N_CLK-1:0] clk_lvl;
    logic [1:0]       fp_lvl;

    tdm_frame_ctr #(.FRAME_CYCLES(FRAME_CYCLES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_q (cnt_q),
        .cnt_d (cnt_d)
    );

    tdm_clk_div #(.CNT_W(CNT_W), .N_CLK(N_CLK)) u_div (
        .idx     (cnt_d),
        .clk_lvl (clk_lvl)
    );

    // index 0: pulse for the 8 MHz clock, index 1: pulse for the 4 MHz clock
    for (genvar p = 0; p < 2; p++) begin : g_fp
        tdm_fp_shaper #(
            .FRAME_CYCLES (FRAME_CYCLES),
            .HALF_WIDTH   (1 << p)
        ) u_fp (
            .idx  (cnt_d),
            .fp_n (fp_lvl[p])
        );
    end

    logic drive_c8;
    logic drive_f8;

    always_comb begin
        d = q;
        if (cfg_wr) begin
            d.cfg.en  = cfg_en;
            d.cfg.ext = cfg_ext;
        end
        drive_c8 = d.cfg.en[EN_C8]  && !d.cfg.ext;
        drive_f8 = d.cfg.en[EN_FP8] && !d.cfg.ext;

        d.pins.c2    = d.cfg.en[EN_C2]  ? clk_lvl[CK_C2] : 1'b1;
        d.pins.c4    = d.cfg.en[EN_C4]  ? clk_lvl[CK_C4] : 1'b1;
        d.pins.fp4   = d.cfg.en[EN_FP4] ? fp_lvl[1]      : 1'b1;
        d.pins.c8    = drive_c8         ? clk_lvl[CK_C8] : 1'b1;
        d.pins.c8_oe = drive_c8;
        d.pins.f8    = drive_f8         ? fp_lvl[0]      : 1'b1;
        d.pins.f8_oe = drive_f8;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg  <= CFG_RST;
            q.pins <= PINS_RST;
        end else begin
            q <= d;
        end
    end

    assign clk2_o = q.pins.c2;
    assign clk4_o = q.pins.c4;
    assign fp4_o  = q.pins.fp4;
    assign c8_o   = q.pins.c8;
    assign c8_oe  = q.pins.c8_oe;
    assign f8_o   = q.pins.f8;
    assign f8_oe  = q.pins.f8_oe;

endmodule

// File: rtl/tdm_clkgen_chk.sv
module tdm_clkgen_chk
    import tdm_clkgen_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [N_OUT-1:0] en_q,
    input logic             ext_q,
    input logic             clk2_o,
    input logic             clk4_o,
    input logic             fp4_o,
    input logic             c8_o,
    input logic             c8_oe,
    input logic             f8_o,
    input logic             f8_oe
);

    assert_c8_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c8_oe && $past(c8_oe)) |-> (c8_o != $past(c8_o)));

    assert_c4_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk4_o) && en_q[EN_C4] && $past(en_q[EN_C4]) && c8_oe && $past(c8_oe))
        |-> $fell(c8_o));

    assert_fp_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (f8_oe && !f8_o && en_q[EN_FP4]) |-> !fp4_o);

    assert_c2_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[EN_C2] |-> clk2_o);

    assert_pad_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!f8_oe |-> f8_o) and (!c8_oe |-> c8_o));

    assert_ext_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q |-> (!c8_oe && !f8_oe));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_wr) |-> ($stable(en_q) && $stable(ext_q)));

endmodule

bind tdm_clkgen tdm_clkgen_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_wr (cfg_wr),
    .en_q   (q.cfg.en),
    .ext_q  (q.cfg.ext),
    .clk2_o (clk2_o),
    .clk4_o (clk4_o),
    .fp4_o  (fp4_o),
    .c8_o   (c8_o),
    .c8_oe  (c8_oe),
    .f8_o   (f8_o),
    .f8_oe  (f8_oe)
);

// File: tb/tdm_clkgen_test.sv
module tdm_clkgen_test;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_en = 5'b0;
    logic       cfg_ext = 1'b0;
    logic       clk2_o, clk4_o, fp4_o, c8_o, c8_oe, f8_o, f8_oe;

    int total = 0;
    int bad   = 0;

    // reference model state
    int         n = 0;
    logic [4:0] men = 5'b0;
    logic       mext = 1'b0;
    bit         started = 1'b0;

    tdm_clkgen #(.FRAME_CYCLES(FRAME)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (cfg_wr),
        .cfg_en (cfg_en),
        .cfg_ext(cfg_ext),
        .clk2_o (clk2_o),
        .clk4_o (clk4_o),
        .fp4_o  (fp4_o),
        .c8_o   (c8_o),
        .c8_oe  (c8_oe),
        .f8_o   (f8_o),
        .f8_oe  (f8_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            n    = 0;
            men  = 5'b0;
            mext = 1'b0;
        end else begin
            n = (n + 1) % FRAME;   // R2 frame index
            if (cfg_wr) begin      // R9 register write
                men  = cfg_en;
                mext = cfg_ext;
            end
        end
    end

    task automatic check(input string tag, input string sig, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s n=%0d actual=%b expected=%b", tag, sig, n, act, exp);
        end
    endtask

    function automatic string tag_of(input string on_tag, input bit en, input bit pad);
        if (!rst_n)        return "R1";
        if (pad && mext)   return "R8";
        if (!en)           return "R7";
        return on_tag;
    endfunction

    always @(negedge clk) begin
        if (started) begin
            logic d8, d_f8;
            d8   = men[2] && !mext;
            d_f8 = men[4] && !mext;
            check(tag_of("R4", men[0], 0), "clk2_o", clk2_o, men[0] ? logic'((n / 4) % 2) : 1'b1);
            check(tag_of("R4", men[1], 0), "clk4_o", clk4_o, men[1] ? logic'((n / 2) % 2) : 1'b1);
            check(tag_of("R3", men[2], 1), "c8_o",   c8_o,   d8 ? logic'(n % 2) : 1'b1);
            check(tag_of("R3", men[2], 1), "c8_oe",  c8_oe,  d8);
            check(tag_of("R6", men[3], 0), "fp4_o",  fp4_o,
                  men[3] ? !(n >= FRAME - 2 || n < 2) : 1'b1);
            check(tag_of("R5", men[4], 1), "f8_o",   f8_o,
                  d_f8 ? !(n == FRAME - 1 || n == 0) : 1'b1);
            check(tag_of("R5", men[4], 1), "f8_oe",  f8_oe,  d_f8);
        end
    end

    task automatic wait_cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [4:0] en, input logic ext);
        @(negedge clk);
        cfg_wr  = 1'b1;
        cfg_en  = en;
        cfg_ext = ext;
        @(negedge clk);
        cfg_wr  = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state held for several cycles
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(10);                       // R1 outputs quiet until written
        write_cfg(5'b11111, 1'b0);             // R3 R4 R5 R6 all running
        wait_cycles(3 * FRAME);
        write_cfg(5'b10101, 1'b0);             // R7 clk4 and fp4 off
        wait_cycles(FRAME + 5);
        write_cfg(5'b01010, 1'b0);             // R7 pads off, clk4 and fp4 on
        wait_cycles(FRAME);
        write_cfg(5'b11111, 1'b1);             // R8 external timing
        wait_cycles(FRAME + 3);
        write_cfg(5'b11111, 1'b0);             // back to local drive
        cfg_en  = 5'b00000;                    // R9 ignored without strobe
        cfg_ext = 1'b1;
        wait_cycles(FRAME / 2);
        @(negedge clk);
        #1 rst_n = 1'b0;                       // R1 R2 mid-run reset
        wait_cycles(3);
        #1 rst_n = 1'b1;
        wait_cycles(8);
        write_cfg(5'b11111, 1'b0);             // R2 phase restarts from 0
        wait_cycles(FRAME + 7);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule